// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the two source register numbers of the instruction sitting in decode against the destinations of the older instructions now in execute and memory. From that comparison it decides whether decode may advance. It also decides which value each execute operand should take in the following cycle.

The register file is read in decode and written in writeback. A write lands in the first half of a cycle and a read happens in the second half, so an instruction in writeback never needs a bypass and is not compared at all. An ALU result produced in execute can be bypassed to the next instruction's execute input, so ALU chains never stall. A load's data only exists after the memory stage. When the instruction directly behind a load uses the loaded register, fetch and decode are held for one cycle and a bubble enters execute.

The operand selects are registered. They are computed while the consumer is still in decode and present during the cycle it spends in execute, which is where the datapath muxes need them. The hold and bubble signals are combinational, because they must act on the pipeline registers at the very next edge.

Top module: `bypass_interlock`

## Requirements
- R1: While reset is high, both operand selects return to 00 (register file) at the next clock edge.
- R2: An operand select is 01 (take the memory-stage result) in the cycle after decode advances with a source equal to the destination of a valid, writing, non-load execute-stage instruction.
- R3: An operand select is 10 (take the writeback-stage result) in the cycle after decode advances with a source that matches a valid, writing memory-stage instruction and no execute-stage producer.
- R4: When the execute-stage and memory-stage producers both match a source, the select is 01, because the younger producer wins.
- R5: A source with no matching producer in execute or memory gets select 00. This includes a producer that has reached writeback, which the split-phase register file already covers.
- R6: The hold output is high in exactly those cycles where decode is valid and the execute stage holds a valid, writing load whose destination equals either source.
- R7: The bubble output is high in exactly the cycles where hold is high.
- R8: Register 0 never causes a bypass select other than 00 and never causes a hold.
- R9: In the cycle after a hold, both selects are 00 (the bubble has no operands). A consumer that waited one cycle behind a load then receives select 10 for the loaded register, and a load-use pair costs exactly one hold cycle.
- R10: Producers that are invalid or do not write are ignored. An invalid decode slot produces no hold and 00 selects in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_src1 | input | REG_W | First source register of decode instruction |
| dec_src2 | input | REG_W | Second source register of decode instruction |
| ex_valid | input | 1 | Execute slot holds an instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_dst | input | REG_W | Execute instruction destination |
| mem_valid | input | 1 | Memory slot holds an instruction |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_dst | input | REG_W | Memory instruction destination |
| hold_fd | output | 1 | Hold the fetch and decode registers |
| kill_ex | output | 1 | Load a bubble into execute at the next edge |
| byp_a | output | 2 | Execute operand A select: 00 file, 01 memory stage, 10 writeback stage |
| byp_b | output | 2 | Execute operand B select, same encoding |

## Verification
The bench builds the block with the default 5-bit register index. Its random phase, however, draws every register number from 0 to 3. That makes producer and source collisions common, so double matches (R4), register-0 cases (R8), and loads colliding with either source (R6) occur many times. A small pipeline model in the bench replays directed instruction sequences: an ALU result consumed at distances one to four, a load followed by its consumer, and a load to register 0. These sequences measure the hold count and check the selects as the consumers pass through execute.

// File: rtl/bi_pkg.sv
package bi_pkg;
  typedef enum logic [1:0] {
    BYP_RF  = 2'b00,
    BYP_MEM = 2'b01,
    BYP_WB  = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/bi_src_match.sv
module bi_src_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             ex_valid,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             mem_valid,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  output logic             ex_hit,
  output logic             mem_hit,
  output logic             load_hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic ex_writes, mem_writes;

  always_comb begin
    ex_writes  = ex_valid && ex_wen && (ex_dst != ZERO_REG);
    mem_writes = mem_valid && mem_wen && (mem_dst != ZERO_REG);
    ex_hit     = ex_writes && (ex_dst == src);
    mem_hit    = mem_writes && (mem_dst == src);
    load_hit   = ex_hit && ex_is_load;
  end
endmodule

// File: rtl/bi_interlock.sv
module bi_interlock #(
  parameter int NSRC = 2
) (
  input  logic            dec_valid,
  input  logic [NSRC-1:0] load_hit,
  output logic            hold,
  output logic            kill
);
  always_comb begin
    hold = dec_valid && (|load_hit);
    kill = hold;
  end
endmodule

// File: rtl/bi_sel_reg.sv
module bi_sel_reg
  import bi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       ex_hit,
  input  logic       mem_hit,
  output logic [1:0] sel
);
  byp_sel_e nxt;

  always_comb begin
    if (clr)          nxt = BYP_RF;
    else if (ex_hit)  nxt = BYP_MEM;
    else if (mem_hit) nxt = BYP_WB;
    else              nxt = BYP_RF;
  end

  always_ff @(posedge clk) begin
    if (rst) sel <= BYP_RF;
    else     sel <= nxt;
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> (sel == BYP_RF));
  assert_ex_first_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && ex_hit) |=> (sel == BYP_MEM));
  assert_mem_pick_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ex_hit && mem_hit) |=> (sel == BYP_WB));
  assert_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sel == BYP_RF));
endmodule

// File: rtl/bypass_interlock.sv
module bypass_interlock
  import bi_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  input  logic [REG_W-1:0] dec_src1,
  input  logic [REG_W-1:0] dec_src2,
  input  logic             ex_valid,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             mem_valid,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  output logic             hold_fd,
  output logic             kill_ex,
  output logic [1:0]       byp_a,
  output logic [1:0]       byp_b
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] srcs [NSRC];
  logic [NSRC-1:0]  ex_hit, mem_hit, load_hit;
  logic [1:0]       sels [NSRC];
  logic             clr;

  always_comb begin
    srcs[0] = dec_src1;
    srcs[1] = dec_src2;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    bi_src_match #(.REG_W(REG_W)) u_match (
      .src       (srcs[i]),
      .ex_valid  (ex_valid),
      .ex_wen    (ex_wen),
      .ex_is_load(ex_is_load),
      .ex_dst    (ex_dst),
      .mem_valid (mem_valid),
      .mem_wen   (mem_wen),
      .mem_dst   (mem_dst),
      .ex_hit    (ex_hit[i]),
      .mem_hit   (mem_hit[i]),
      .load_hit  (load_hit[i])
    );

    bi_sel_reg u_sel (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .ex_hit (ex_hit[i]),
      .mem_hit(mem_hit[i]),
      .sel    (sels[i])
    );
  end

  bi_interlock #(.NSRC(NSRC)) u_lock (
    .dec_valid(dec_valid),
    .load_hit (load_hit),
    .hold     (hold_fd),
    .kill     (kill_ex)
  );

  always_comb clr = hold_fd || !dec_valid;

  assign byp_a = sels[0];
  assign byp_b = sels[1];

  assert_zero_src_R8: assert property (@(posedge clk) disable iff (rst)
    (dec_src1 == '0 && dec_src2 == '0) |-> !hold_fd);
  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    (byp_a != 2'b11) && (byp_b != 2'b11));
  assert_bubble_R7: assert property (@(posedge clk) disable iff (rst)
    kill_ex == hold_fd);
  assert_no_dec_R10: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> (byp_a == BYP_RF) && (byp_b == BYP_RF));
endmodule

// File: tb/bypass_interlock_test.sv
`timescale 1ns/1ps
module bypass_interlock_test;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst;
  logic dv, ev, ew, el, mv, mw;
  logic [REG_W-1:0] s1, s2, ed, md;
  logic hold_fd, kill_ex;
  logic [1:0] byp_a, byp_b;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  bypass_interlock #(.REG_W(REG_W)) uut (
    .clk(clk), .rst(rst),
    .dec_valid(dv), .dec_src1(s1), .dec_src2(s2),
    .ex_valid(ev), .ex_wen(ew), .ex_is_load(el), .ex_dst(ed),
    .mem_valid(mv), .mem_wen(mw), .mem_dst(md),
    .hold_fd(hold_fd), .kill_ex(kill_ex), .byp_a(byp_a), .byp_b(byp_b)
  );

  function automatic logic exp_hold();
    return dv && ev && ew && el && (ed != 0) && (ed == s1 || ed == s2);
  endfunction

  function automatic logic [1:0] exp_sel(logic [REG_W-1:0] src);
    if (!dv || exp_hold()) return 2'b00;
    if (ev && ew && ed != 0 && ed == src) return 2'b01;
    if (mv && mw && md != 0 && md == src) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // inputs are already driven; checks hold now and selects after the edge
  task automatic step(string tag);
    logic eh;
    logic [1:0] ea, eb;
    #1;
    eh = exp_hold();
    ea = exp_sel(s1);
    eb = exp_sel(s2);
    check({tag, " hold R6"}, {1'b0, hold_fd}, {1'b0, eh});
    check({tag, " bubble R7"}, {1'b0, kill_ex}, {1'b0, eh});
    @(posedge clk);
    @(negedge clk);
    check({tag, " sel A R2/R3"}, byp_a, ea);
    check({tag, " sel B R2/R3"}, byp_b, eb);
  endtask

  // pipeline model for directed sequences
  int p_dst[8], p_s1[8], p_s2[8];
  bit p_ld[8];

  task automatic run_prog(int n, int exp_stalls, string tag);
    int pc = 0;
    int stalls = 0;
    bit e_v = 0, e_l = 0, m_v = 0;
    int e_d = 0, m_d = 0;
    for (int cyc = 0; cyc < n + 5; cyc++) begin
      dv = (pc < n);
      s1 = (pc < n) ? REG_W'(p_s1[pc]) : '0;
      s2 = (pc < n) ? REG_W'(p_s2[pc]) : '0;
      ev = e_v; ew = e_v; el = e_l; ed = REG_W'(e_d);
      mv = m_v; mw = m_v; md = REG_W'(m_d);
      #1;
      if (hold_fd) stalls++;
      m_v = e_v; m_d = e_d;
      if (hold_fd || pc >= n) begin
        e_v = 0; e_l = 0; e_d = 0;
      end else begin
        e_v = 1; e_l = p_ld[pc]; e_d = p_dst[pc]; pc++;
      end
      #(-0.0);
      step(tag);
    end
    check({tag, " stall count R9"}, 2'(stalls), 2'(exp_stalls));
  endtask

  task automatic set_ins(int i, int d, int a, int b, bit ld);
    p_dst[i] = d; p_s1[i] = a; p_s2[i] = b; p_ld[i] = ld;
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    dv = 0; ev = 0; ew = 0; el = 0; mv = 0; mw = 0;
    s1 = 0; s2 = 0; ed = 0; md = 0;
    @(negedge clk);
    dv = 1; s1 = 3; s2 = 3; ev = 1; ew = 1; ed = 3;
    @(posedge clk);
    @(negedge clk);
    check("reset sel A R1", byp_a, 2'b00);
    check("reset sel B R1", byp_b, 2'b00);
    rst = 1'b0;

    // ALU producer then dependents at distances 1..4 (R2, R3, R5)
    set_ins(0, 1, 2, 3, 0);
    set_ins(1, 4, 5, 1, 0);
    set_ins(2, 6, 1, 7, 0);
    set_ins(3, 8, 1, 9, 0);
    set_ins(4, 10, 1, 11, 0);
    run_prog(5, 0, "alu chain");

    // two producers of the same register: younger wins (R4)
    set_ins(0, 1, 2, 3, 0);
    set_ins(1, 1, 4, 5, 0);
    set_ins(2, 6, 1, 1, 0);
    run_prog(3, 0, "double producer R4");

    // load followed by its consumer: one stall (R6, R7, R9)
    set_ins(0, 4, 1, 0, 1);
    set_ins(1, 5, 4, 4, 0);
    set_ins(2, 6, 4, 2, 0);
    run_prog(3, 1, "load use");

    // load into register 0 and its consumer: nothing (R8)
    set_ins(0, 0, 1, 0, 1);
    set_ins(1, 5, 0, 0, 0);
    run_prog(2, 0, "zero reg R8");

    // random snapshots, small register range (R2..R8, R10)
    for (int k = 0; k < 3000; k++) begin
      dv = 1'($urandom); s1 = REG_W'($urandom_range(0, 3));
      s2 = REG_W'($urandom_range(0, 3));
      ev = 1'($urandom); ew = 1'($urandom); el = 1'($urandom);
      ed = REG_W'($urandom_range(0, 3));
      mv = 1'($urandom); mw = 1'($urandom);
      md = REG_W'($urandom_range(0, 3));
      step("random R10");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule